// File: doc/BRIEF.md
# Chained Frame Descriptor Fetcher

This block moves frame data from memory into a downstream pixel FIFO. A linked list of frame descriptors held in memory tells it what to fetch. Each descriptor is four consecutive 32-bit words: the address of the following descriptor, the base address of the frame buffer, a frame identifier, and a command word. The low bits of the command word give the frame length in 32-bit words. Three flag bits in the same word mark the frame as palette data and ask for a start-of-frame or an end-of-frame interrupt pulse.

Software writes the address of the first descriptor into the head register and then raises `enable`. The fetcher reads that descriptor and then streams the frame buffer as read bursts of 4, 8 or 16 words. It asks for a burst only when the FIFO reports room for all of it, and it cuts the last burst of a frame down to the words that are left. When a frame is finished it follows the next pointer, so a descriptor that links to itself shows the same buffer again every frame. When `enable` drops, the fetcher completes the burst in progress and then goes idle. The next `enable` starts again from the head register.

Top module: `frame_desc_fetcher`

## Requirements
- R1: A rising `enable` seen while idle starts a read of exactly 4 words at the address held in the head register. The returned words are taken as next pointer, buffer base, frame ID and command, in that order. A write to `head_addr` while `enable` is low does not start any activity.
- R2: Each frame pushes exactly `cmd[15:0]` words into the FIFO. The first word comes from the buffer base and each later word from the next word address, in order. A length of 0 pushes nothing.
- R3: Each data burst has length 4, 8 or 16 for `burst_sel` 0, 1 or 2, and `burst_sel` 3 also selects 16. The final burst of a frame is shortened to the words that remain. Bursts of one frame cover consecutive addresses.
- R4: A data burst is requested only when `fifo_free` is at least the burst length, so the FIFO never overflows.
- R5: `sof_irq` pulses for one cycle when a descriptor with `cmd[31]` set has been loaded. `eof_irq` pulses for one cycle after the last word of a frame whose `cmd[30]` is set, including a zero-length frame.
- R6: `fifo_palette` equals `cmd[28]` of the current frame for every pushed word.
- R7: After a frame completes, the next descriptor is fetched from the address in that frame's next field. A self-linked descriptor repeats its frame.
- R8: `cur_frame_id` holds the ID word of the most recently loaded descriptor.
- R9: When `enable` is low, the burst in flight completes and no further request is issued. `active` then falls, and a later enable restarts from the head register.
- R10: A request that has been raised holds its address and length until `rd_req_ready` accepts it.
- R11: After reset the block is idle: no request, no push, no interrupt pulse, and `cur_frame_id` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| enable | input | 1 | Run request |
| head_we | input | 1 | Head register write strobe |
| head_addr | input | ADDR_W | First descriptor byte address |
| burst_sel | input | 2 | Data burst length select |
| rd_req_valid | output | 1 | Read request valid |
| rd_req_ready | input | 1 | Read request accepted |
| rd_req_addr | output | ADDR_W | Read byte address |
| rd_req_len | output | REQ_LEN_W | Read length in words |
| rd_rsp_valid | input | 1 | Read data beat valid |
| rd_rsp_data | input | 32 | Read data beat |
| fifo_push | output | 1 | FIFO write strobe |
| fifo_data | output | 32 | FIFO write word |
| fifo_palette | output | 1 | Word belongs to a palette frame |
| fifo_free | input | FREE_W | Free FIFO entries |
| sof_irq | output | 1 | Start-of-frame interrupt pulse |
| eof_irq | output | 1 | End-of-frame interrupt pulse |
| cur_frame_id | output | 32 | ID of the last loaded descriptor |
| active | output | 1 | Fetcher not idle |

## Verification
The hardest case to reach is a stop that falls exactly on a frame boundary, or in the middle of a burst. From the ports this needs `enable` to drop on the very cycle a particular data word arrives. The bench therefore ties `enable` to its own count of data words presented by the memory model, so `enable` falls in the same half cycle as the chosen word. Data responses carry periodic gaps, request acceptance is stalled, and the FIFO drains slowly. Together these hold requests pending, exercise the room check, and keep the end-of-frame and disable decisions from lining up with any regular beat pattern.

// File: rtl/fdf_pkg.sv
package fdf_pkg;

  localparam int unsigned WORD_BYTES  = 4;
  localparam int unsigned DESC_WORDS  = 4;
  localparam int unsigned CMD_SOF_BIT = 31;
  localparam int unsigned CMD_EOF_BIT = 30;
  localparam int unsigned CMD_PAL_BIT = 28;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_DREQ,
    ST_DRSP,
    ST_BREQ,
    ST_BRSP,
    ST_FEND
  } fetch_state_e;

endpackage

// File: rtl/fdf_desc_capture.sv
module fdf_desc_capture #(
  parameter int unsigned ADDR_W = 32,
  parameter int unsigned LEN_W  = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              restart,
  input  logic              beat_valid,
  input  logic [31:0]       beat_data,
  output logic              done,
  output logic [ADDR_W-1:0] next_ptr,
  output logic [ADDR_W-1:0] fbuf_ptr,
  output logic [31:0]       frame_id,
  output logic [LEN_W-1:0]  frame_len,
  output logic              want_sof,
  output logic              want_eof,
  output logic              palette
);
  import fdf_pkg::*;

  localparam int unsigned HELD = DESC_WORDS - 1;
  localparam int unsigned IDX_W = $clog2(DESC_WORDS);

  logic [IDX_W-1:0] idx_q, idx_d;
  logic [31:0]      word_q [HELD];

  always_comb begin
    idx_d = idx_q;
    if (restart) begin
      idx_d = '0;
    end else if (beat_valid) begin
      idx_d = idx_q + IDX_W'(1);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      idx_q <= '0;
    end else begin
      idx_q <= idx_d;
    end
  end

  for (genvar g = 0; g < HELD; g++) begin : g_word
    logic hit;
    assign hit = beat_valid && (idx_q == IDX_W'(g));
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        word_q[g] <= '0;
      end else if (hit) begin
        word_q[g] <= beat_data;
      end
    end
  end

  assign done      = beat_valid && (idx_q == IDX_W'(HELD));
  assign next_ptr  = word_q[0][ADDR_W-1:0];
  assign fbuf_ptr  = word_q[1][ADDR_W-1:0];
  assign frame_id  = word_q[2];
  assign frame_len = beat_data[LEN_W-1:0];
  assign want_sof  = beat_data[CMD_SOF_BIT];
  assign want_eof  = beat_data[CMD_EOF_BIT];
  assign palette   = beat_data[CMD_PAL_BIT];

endmodule

// File: rtl/fdf_burst_sizer.sv
module fdf_burst_sizer #(
  parameter int unsigned LEN_W     = 16,
  parameter int unsigned FREE_W    = 6,
  parameter int unsigned REQ_LEN_W = 5
) (
  input  logic [1:0]           burst_sel,
  input  logic [LEN_W-1:0]     remaining,
  input  logic [FREE_W-1:0]    fifo_free,
  output logic [REQ_LEN_W-1:0] burst_len,
  output logic                 room_ok
);

  localparam int unsigned WIDER = (LEN_W > FREE_W) ? LEN_W : FREE_W;
  localparam int unsigned CW    = ((WIDER > REQ_LEN_W) ? WIDER : REQ_LEN_W) + 1;

  logic [REQ_LEN_W-1:0] full_len;
  logic [CW-1:0]        rem_x;
  logic [CW-1:0]        full_x;

  always_comb begin
    unique case (burst_sel)
      2'd0:    full_len = REQ_LEN_W'(4);
      2'd1:    full_len = REQ_LEN_W'(8);
      default: full_len = REQ_LEN_W'(16);
    endcase
  end

  always_comb begin
    rem_x  = CW'(remaining);
    full_x = CW'(full_len);
    if (rem_x < full_x) begin
      burst_len = REQ_LEN_W'(remaining);
    end else begin
      burst_len = full_len;
    end
    room_ok = CW'(fifo_free) >= CW'(burst_len);
  end

endmodule

// File: rtl/fdf_frame_walker.sv
module fdf_frame_walker #(
  parameter int unsigned ADDR_W    = 32,
  parameter int unsigned LEN_W     = 16,
  parameter int unsigned REQ_LEN_W = 5
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 load,
  input  logic [ADDR_W-1:0]    load_addr,
  input  logic [LEN_W-1:0]     load_len,
  input  logic                 burst_go,
  input  logic [REQ_LEN_W-1:0] burst_len,
  input  logic                 beat,
  output logic [ADDR_W-1:0]    addr,
  output logic [LEN_W-1:0]     remaining,
  output logic                 last_beat,
  output logic                 last_word
);
  import fdf_pkg::*;

  logic [ADDR_W-1:0]    addr_q, addr_d;
  logic [LEN_W-1:0]     rem_q, rem_d;
  logic [REQ_LEN_W-1:0] beats_q, beats_d;

  always_comb begin
    addr_d  = addr_q;
    rem_d   = rem_q;
    beats_d = beats_q;
    if (load) begin
      addr_d = load_addr;
      rem_d  = load_len;
    end else if (beat) begin
      addr_d = addr_q + ADDR_W'(WORD_BYTES);
      rem_d  = rem_q - LEN_W'(1);
    end
    if (burst_go) begin
      beats_d = burst_len;
    end else if (beat) begin
      beats_d = beats_q - REQ_LEN_W'(1);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      addr_q  <= '0;
      rem_q   <= '0;
      beats_q <= '0;
    end else begin
      addr_q  <= addr_d;
      rem_q   <= rem_d;
      beats_q <= beats_d;
    end
  end

  assign addr      = addr_q;
  assign remaining = rem_q;
  assign last_beat = beats_q == REQ_LEN_W'(1);
  assign last_word = rem_q == LEN_W'(1);

endmodule

// File: rtl/frame_desc_fetcher.sv
module frame_desc_fetcher #(
  parameter int unsigned ADDR_W    = 32,
  parameter int unsigned LEN_W     = 16,
  parameter int unsigned FREE_W    = 6,
  parameter int unsigned REQ_LEN_W = 5
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 enable,
  input  logic                 head_we,
  input  logic [ADDR_W-1:0]    head_addr,
  input  logic [1:0]           burst_sel,
  output logic                 rd_req_valid,
  input  logic                 rd_req_ready,
  output logic [ADDR_W-1:0]    rd_req_addr,
  output logic [REQ_LEN_W-1:0] rd_req_len,
  input  logic                 rd_rsp_valid,
  input  logic [31:0]          rd_rsp_data,
  output logic                 fifo_push,
  output logic [31:0]          fifo_data,
  output logic                 fifo_palette,
  input  logic [FREE_W-1:0]    fifo_free,
  output logic                 sof_irq,
  output logic                 eof_irq,
  output logic [31:0]          cur_frame_id,
  output logic                 active
);
  import fdf_pkg::*;

  fetch_state_e state_q, state_d;

  logic [ADDR_W-1:0] head_q;
  logic [ADDR_W-1:0] desc_addr_q, desc_addr_d;
  logic [ADDR_W-1:0] next_q;
  logic              eof_want_q;
  logic              pal_q;
  logic [31:0]       frame_id_q;
  logic              sof_q, eof_q;

  logic              req_fire;
  logic              req_is_data;
  logic              desc_beat;
  logic              push;

  logic              desc_done;
  logic [ADDR_W-1:0] cap_next;
  logic [ADDR_W-1:0] cap_fbuf;
  logic [31:0]       cap_id;
  logic [LEN_W-1:0]  cap_len;
  logic              cap_sof, cap_eof, cap_pal;

  logic [REQ_LEN_W-1:0] blen;
  logic                 room_ok;
  logic [ADDR_W-1:0]    walk_addr;
  logic [LEN_W-1:0]     walk_rem;
  logic                 walk_last_beat, walk_last_word;

  fdf_desc_capture #(
    .ADDR_W (ADDR_W),
    .LEN_W  (LEN_W)
  ) i_capture (
    .clk        (clk),
    .rst_n      (rst_n),
    .restart    (state_q == ST_DREQ),
    .beat_valid (desc_beat),
    .beat_data  (rd_rsp_data),
    .done       (desc_done),
    .next_ptr   (cap_next),
    .fbuf_ptr   (cap_fbuf),
    .frame_id   (cap_id),
    .frame_len  (cap_len),
    .want_sof   (cap_sof),
    .want_eof   (cap_eof),
    .palette    (cap_pal)
  );

  fdf_burst_sizer #(
    .LEN_W     (LEN_W),
    .FREE_W    (FREE_W),
    .REQ_LEN_W (REQ_LEN_W)
  ) i_sizer (
    .burst_sel (burst_sel),
    .remaining (walk_rem),
    .fifo_free (fifo_free),
    .burst_len (blen),
    .room_ok   (room_ok)
  );

  fdf_frame_walker #(
    .ADDR_W    (ADDR_W),
    .LEN_W     (LEN_W),
    .REQ_LEN_W (REQ_LEN_W)
  ) i_walker (
    .clk       (clk),
    .rst_n     (rst_n),
    .load      (desc_done),
    .load_addr (cap_fbuf),
    .load_len  (cap_len),
    .burst_go  (req_fire && req_is_data),
    .burst_len (blen),
    .beat      (push),
    .addr      (walk_addr),
    .remaining (walk_rem),
    .last_beat (walk_last_beat),
    .last_word (walk_last_word)
  );

  // Request side
  always_comb begin
    req_is_data  = state_q == ST_BREQ;
    rd_req_valid = (state_q == ST_DREQ) || (req_is_data && room_ok);
    if (state_q == ST_DREQ) begin
      rd_req_addr = desc_addr_q;
      rd_req_len  = REQ_LEN_W'(DESC_WORDS);
    end else begin
      rd_req_addr = walk_addr;
      rd_req_len  = blen;
    end
    req_fire  = rd_req_valid && rd_req_ready;
    desc_beat = (state_q == ST_DRSP) && rd_rsp_valid;
    push      = (state_q == ST_BRSP) && rd_rsp_valid;
  end

  // Next state
  always_comb begin
    state_d     = state_q;
    desc_addr_d = desc_addr_q;
    unique case (state_q)
      ST_IDLE: begin
        if (enable) begin
          state_d     = ST_DREQ;
          desc_addr_d = head_q;
        end
      end
      ST_DREQ: begin
        if (req_fire) state_d = ST_DRSP;
      end
      ST_DRSP: begin
        if (desc_done) begin
          if (cap_len == '0)  state_d = ST_FEND;
          else if (!enable)   state_d = ST_IDLE;
          else                state_d = ST_BREQ;
        end
      end
      ST_BREQ: begin
        if (req_fire) state_d = ST_BRSP;
      end
      ST_BRSP: begin
        if (push && walk_last_beat) begin
          if (walk_last_word) state_d = ST_FEND;
          else if (!enable)   state_d = ST_IDLE;
          else                state_d = ST_BREQ;
        end
      end
      ST_FEND: begin
        desc_addr_d = next_q;
        state_d     = enable ? ST_DREQ : ST_IDLE;
      end
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q     <= ST_IDLE;
      desc_addr_q <= '0;
      sof_q       <= 1'b0;
      eof_q       <= 1'b0;
    end else begin
      state_q     <= state_d;
      desc_addr_q <= desc_addr_d;
      sof_q       <= desc_done && cap_sof;
      eof_q       <= (state_q == ST_FEND) && eof_want_q;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      head_q <= '0;
    end else if (head_we) begin
      head_q <= head_addr;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      next_q     <= '0;
      eof_want_q <= 1'b0;
      pal_q      <= 1'b0;
      frame_id_q <= '0;
    end else if (desc_done) begin
      next_q     <= cap_next;
      eof_want_q <= cap_eof;
      pal_q      <= cap_pal;
      frame_id_q <= cap_id;
    end
  end

  assign fifo_push    = push;
  assign fifo_data    = rd_rsp_data;
  assign fifo_palette = pal_q;
  assign sof_irq      = sof_q;
  assign eof_irq      = eof_q;
  assign cur_frame_id = frame_id_q;
  assign active       = state_q != ST_IDLE;

endmodule

// File: rtl/fdf_checker.sv
module fdf_checker #(
  parameter int unsigned ADDR_W    = 32,
  parameter int unsigned FREE_W    = 6,
  parameter int unsigned REQ_LEN_W = 5
) (
  input logic                 clk,
  input logic                 rst_n,
  input logic                 rd_req_valid,
  input logic                 rd_req_ready,
  input logic [ADDR_W-1:0]    rd_req_addr,
  input logic [REQ_LEN_W-1:0] rd_req_len,
  input logic                 req_is_data,
  input logic                 rd_rsp_valid,
  input logic                 fifo_push,
  input logic [FREE_W-1:0]    fifo_free,
  input logic                 sof_irq,
  input logic                 eof_irq,
  input logic                 active
);

  AST_REQ_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    rd_req_valid && !rd_req_ready |=> rd_req_valid && $stable(rd_req_addr) && $stable(rd_req_len)); // R10

  AST_BURST_FITS: assert property (@(posedge clk) disable iff (!rst_n)
    rd_req_valid && req_is_data |-> int'(rd_req_len) <= int'(fifo_free)); // R4

  AST_LEN_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    rd_req_valid |-> rd_req_len != '0 && int'(rd_req_len) <= 16); // R3

  AST_SOF_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    sof_irq |=> !sof_irq); // R5

  AST_EOF_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    eof_irq |=> !eof_irq); // R5

  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    !active |-> !rd_req_valid && !fifo_push); // R9

  AST_PUSH_FROM_RSP: assert property (@(posedge clk) disable iff (!rst_n)
    fifo_push |-> rd_rsp_valid); // R2

endmodule

bind frame_desc_fetcher fdf_checker #(
  .ADDR_W    (ADDR_W),
  .FREE_W    (FREE_W),
  .REQ_LEN_W (REQ_LEN_W)
) i_fdf_checker (
  .clk          (clk),
  .rst_n        (rst_n),
  .rd_req_valid (rd_req_valid),
  .rd_req_ready (rd_req_ready),
  .rd_req_addr  (rd_req_addr),
  .rd_req_len   (rd_req_len),
  .req_is_data  (req_is_data),
  .rd_rsp_valid (rd_rsp_valid),
  .fifo_push    (fifo_push),
  .fifo_free    (fifo_free),
  .sof_irq      (sof_irq),
  .eof_irq      (eof_irq),
  .active       (active)
);

// File: tb/test_frame_desc_fetcher.sv
`timescale 1ns/100ps
module test_frame_desc_fetcher;

  localparam int CAP = 20;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        enable;
  logic        head_we;
  logic [31:0] head_addr;
  logic [1:0]  bsel;
  logic        rd_req_valid;
  logic        rd_req_ready;
  logic [31:0] rd_req_addr;
  logic [4:0]  rd_req_len;
  logic        rd_rsp_valid;
  logic [31:0] rd_rsp_data;
  logic        fifo_push;
  logic [31:0] fifo_data;
  logic        fifo_palette;
  logic [5:0]  fifo_free;
  logic        sof_irq, eof_irq;
  logic [31:0] cur_frame_id;
  logic        active;

  always #2.5 clk = ~clk;

  logic [31:0] mem [0:1023];
  logic [31:0] log_d [0:4095];
  logic        log_p [0:4095];
  int log_n = 0, sof_n = 0, eof_n = 0;
  int words_presented = 0, stop_at = 0;
  logic run_en;
  int checks = 0, errs = 0, a_checks = 0, a_errs = 0;

  assign enable = run_en && (words_presented < stop_at);

  frame_desc_fetcher i_frame_desc_fetcher (
    .clk(clk), .rst_n(rst_n), .enable(enable), .head_we(head_we), .head_addr(head_addr),
    .burst_sel(bsel), .rd_req_valid(rd_req_valid), .rd_req_ready(rd_req_ready),
    .rd_req_addr(rd_req_addr), .rd_req_len(rd_req_len), .rd_rsp_valid(rd_rsp_valid),
    .rd_rsp_data(rd_rsp_data), .fifo_push(fifo_push), .fifo_data(fifo_data),
    .fifo_palette(fifo_palette), .fifo_free(fifo_free), .sof_irq(sof_irq),
    .eof_irq(eof_irq), .cur_frame_id(cur_frame_id), .active(active)
  );

  function automatic int full_burst(input logic [1:0] s);
    return (s == 2'd0) ? 4 : (s == 2'd1) ? 8 : 16;
  endfunction

  // Memory responder and FIFO model
  initial begin
    int occ, cyc, r_beat, r_len, exp_rem, exp_len, idx;
    logic pend, is_desc;
    logic [31:0] r_addr, exp_addr;
    occ = 0; cyc = 0; pend = 0; is_desc = 0; r_beat = 0; r_len = 0;
    exp_rem = 0; exp_addr = 0; r_addr = 0;
    rd_req_ready = 0; rd_rsp_valid = 0; rd_rsp_data = 0; fifo_free = 6'(CAP);
    forever begin
      @(negedge clk);
      cyc++;
      rd_req_ready = 0;
      rd_rsp_valid = 0;
      if (rst_n !== 1'b1) begin
        pend = 0; occ = 0;
      end else begin
        if (occ > 0 && cyc % 3 == 0) occ--;
        if (pend) begin
          if (cyc % 5 != 2) begin
            idx = int'((r_addr >> 2) & 32'h3FF);
            rd_rsp_valid = 1;
            rd_rsp_data  = mem[(idx + r_beat) & 1023];
            if (!is_desc) words_presented++;
            r_beat++;
            if (r_beat == r_len) begin
              pend = 0;
              if (is_desc) begin
                exp_rem  = int'(mem[idx + 3][15:0]);
                exp_addr = mem[idx + 1];
              end
            end
          end
        end else if (rd_req_valid && (cyc % 4) != 1) begin
          rd_req_ready = 1;
          r_addr = rd_req_addr; r_len = int'(rd_req_len); r_beat = 0; pend = 1;
          is_desc = rd_req_addr < 32'h400;
          a_checks++;
          if (is_desc) begin
            if (r_len != 4) begin
              a_errs++;
              $display("FAIL R1 descriptor read length: actual %0d expected 4", r_len);
            end
          end else begin
            exp_len = (exp_rem < full_burst(bsel)) ? exp_rem : full_burst(bsel);
            if (r_len != exp_len || r_addr != exp_addr) begin
              a_errs++;
              $display("FAIL R3 burst: actual len %0d addr %h expected len %0d addr %h",
                       r_len, r_addr, exp_len, exp_addr);
            end
            a_checks++;
            if (r_len > CAP - occ) begin
              a_errs++;
              $display("FAIL R4 burst without room: actual len %0d expected <= %0d", r_len, CAP - occ);
            end
            exp_rem  = exp_rem - r_len;
            exp_addr = exp_addr + 32'(4 * r_len);
          end
        end
      end
      fifo_free = 6'(CAP - occ);
      #1;
      if (fifo_push === 1'b1) begin
        log_d[log_n & 4095] = fifo_data;
        log_p[log_n & 4095] = fifo_palette;
        log_n++;
        occ++;
        if (occ > CAP) begin
          a_checks++; a_errs++;
          $display("FAIL R4 FIFO overflow: actual %0d expected <= %0d", occ, CAP);
        end
      end
      if (sof_irq === 1'b1) sof_n++;
      if (eof_irq === 1'b1) eof_n++;
    end
  end

  task automatic check(input bit ok, input string what, input int act, input int expv);
    checks++;
    if (!ok) begin
      errs++;
      $display("FAIL %s: actual %0d (0x%h) expected %0d (0x%h)", what, act, act, expv, expv);
    end
  endtask

  task automatic put_desc(input int at, input logic [31:0] nxt, input logic [31:0] buf_a,
                          input logic [31:0] id, input logic [31:0] cmd);
    mem[at >> 2]       = nxt;
    mem[(at >> 2) + 1] = buf_a;
    mem[(at >> 2) + 2] = id;
    mem[(at >> 2) + 3] = cmd;
  endtask

  // Program the head, run until the stop point, compare the pushed stream
  task automatic run_chain(input logic [31:0] head, input int stop_words, input int exp_words);
    int base_log, base_sof, base_eof, waited, total, take, len, exp_sof, exp_eof, bad_d, bad_p, d, b;
    logic [31:0] cmd, last_id;
    @(negedge clk); head_we = 1; head_addr = head;
    @(negedge clk); head_we = 0;
    base_log = log_n; base_sof = sof_n; base_eof = eof_n;
    stop_at = words_presented + stop_words;
    run_en = 1;
    waited = 0;
    @(negedge clk);
    while (!(enable == 1'b0 && active == 1'b0) && waited < 20000) begin
      @(negedge clk); waited++;
    end
    repeat (4) @(negedge clk);
    run_en = 0;
    check(waited < 20000, "R9 fetcher returns idle after stop", waited, 0);
    d = int'(head); total = 0; exp_sof = 0; exp_eof = 0; bad_d = 0; bad_p = 0; last_id = 0;
    for (int f = 0; f < 64 && total < exp_words; f++) begin
      cmd = mem[(d >> 2) + 3];
      len = int'(cmd[15:0]);
      last_id = mem[(d >> 2) + 2];
      b = int'(mem[(d >> 2) + 1]) >> 2;
      if (cmd[31]) exp_sof++;
      take = (len < exp_words - total) ? len : exp_words - total;
      for (int i = 0; i < take; i++) begin
        if (log_d[(base_log + total + i) & 4095] !== mem[(b + i) & 1023]) bad_d++;
        if (log_p[(base_log + total + i) & 4095] !== cmd[28]) bad_p++;
      end
      total += take;
      if (take == len && cmd[30]) exp_eof++;
      d = int'(mem[d >> 2]);
    end
    check(log_n - base_log == exp_words, "R2 pushed word count", log_n - base_log, exp_words);
    check(bad_d == 0, "R7 pushed data follows chain", bad_d, 0);
    check(bad_p == 0, "R6 palette flag", bad_p, 0);
    check(sof_n - base_sof == exp_sof, "R5 sof pulses", sof_n - base_sof, exp_sof);
    check(eof_n - base_eof == exp_eof, "R5 eof pulses", eof_n - base_eof, exp_eof);
    check(cur_frame_id == last_id, "R8 current frame id", int'(cur_frame_id), int'(last_id));
  endtask

  initial begin
    int l0, l1;
    for (int i = 0; i < 1024; i++) mem[i] = (32'(i) * 32'h0100_0193) ^ 32'hA5A5_0000;
    rst_n = 0; run_en = 0; head_we = 0; head_addr = 0; bsel = 0;
    repeat (4) @(negedge clk);
    // R11 reset state
    check(active == 1'b0, "R11 idle after reset", int'(active), 0);
    check(rd_req_valid == 1'b0 && fifo_push == 1'b0, "R11 no request or push", int'(rd_req_valid), 0);
    check(sof_irq == 1'b0 && eof_irq == 1'b0, "R11 no interrupt", int'(sof_irq | eof_irq), 0);
    check(cur_frame_id == 32'h0, "R11 frame id cleared", int'(cur_frame_id), 0);
    rst_n = 1;
    // R1 head write without enable starts nothing
    @(negedge clk); head_we = 1; head_addr = 32'h40;
    @(negedge clk); head_we = 0;
    repeat (6) @(negedge clk);
    check(active == 1'b0 && rd_req_valid == 1'b0, "R1 head write alone stays idle", int'(active), 0);

    // R3 R7 sweep: two-descriptor chain, second links to itself
    for (int p = 0; p < 4; p++) begin
      for (int s = 0; s < 4; s++) begin
        l0 = (p == 0) ? 1 : (p == 1) ? 5 : (p == 2) ? 16 : 23;
        l1 = (p == 0) ? 3 : (p == 1) ? 13 : (p == 2) ? 8 : 2;
        put_desc(32'h40, 32'h80, 32'h400, 32'hC0DE_0000 + 32'(p * 16 + s),
                 32'(l0) | 32'h8000_0000 | ((p % 2 == 1) ? 32'h4000_0000 : 32'h0));
        put_desc(32'h80, 32'h80, 32'h800, 32'hC0DE_0100 + 32'(p * 16 + s),
                 32'(l1) | 32'h4000_0000 | 32'h1000_0000 | ((s % 2 == 1) ? 32'h8000_0000 : 32'h0));
        bsel = 2'(s);
        run_chain(32'h40, l0 + 2 * l1, l0 + 2 * l1);
      end
    end

    // R9 stop in mid burst: 8-word bursts, stop presented on word 11, burst completes to 16
    bsel = 2'd1;
    put_desc(32'hC0, 32'hC0, 32'h600, 32'hFEED_0001, 32'd40 | 32'hC000_0000);
    run_chain(32'hC0, 11, 16);
    // R9 restart from a new head
    bsel = 2'd2;
    run_chain(32'h40, 27, 27);

    // R2 R5 zero-length frame followed by a self-linked short frame
    bsel = 2'd0;
    put_desc(32'h100, 32'h140, 32'h700, 32'hBEEF_0000, 32'hC000_0000);
    put_desc(32'h140, 32'h140, 32'h780, 32'hBEEF_0001, 32'd3 | 32'h4000_0000);
    run_chain(32'h100, 3, 3);

    $display("Simulation finished: %0d checks, %0d errors", checks + a_checks, errs + a_errs);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks + a_checks + 1, errs + a_errs + 1);
    $finish;
  end

endmodule